// File: doc/BRIEF.md
# Coherent Four-Phase Baseband Symbol Demodulator

This block turns a stream of signed 8-bit samples of a four-phase PSK carrier into 2-bit symbol decisions. Each accepted sample is mixed with two signed 8-bit local references. One reference sits 45 degrees ahead of the recovered carrier and the other 45 degrees behind it, which gives two correlator branches, A (ahead) and B (behind). Each branch is smoothed by a constant-coefficient low-pass FIR and then shaped by a constant-coefficient matched FIR. Every tap product in both filters is a sum of signed power-of-two shifts; no general multiplier is used.

A free-running counter marks one sampling instant per symbol. The counter advances on accepted samples. At that instant the signs of the two matched-filter outputs are mapped to a Gray-coded symbol. Samples enter on a valid/ready stream, and symbols leave on a valid/ready stream. While an undelivered symbol is stalled at the output, the input stream is held off. This freezes the filters and the counter, so no sample is skipped or counted twice under back-pressure.

Top module: `qpsk_demod_top`

## Requirements
- R1: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While a sample is refused, the filters and the symbol counter hold their state.
- R2: For accepted sample n, the branch A product is pA[n] = sample * ref_ahead and the branch B product is pB[n] = sample * ref_behind. Both products are full 16-bit two's-complement values with no loss, so -128 * -128 gives +16384.
- R3: Low-pass stage. For each branch, l[n] = floor((-p[n] + 6p[n-1] + 13p[n-2] + 6p[n-3] - p[n-4]) / 32), with p at negative indices taken as 0. The sum is kept at full width and truncated to 16 bits only at the output.
- R4: Matched stage. For each branch, m[n] = floor((3l[n] + 11l[n-1] + 11l[n-2] + 3l[n-3]) / 32), with l at negative indices taken as 0. The sum is kept at full width and truncated to 16 bits only at the output.
- R5: Accepted samples are numbered j = 0, 1, 2, ... from reset. Sample j produces a symbol when j mod SPS equals PHASE (defaults 4 and 2). That symbol is decided from mA[j-2] and mB[j-2], with 0 used when j < 2.
- R6: The decision maps the signs of (branch A, branch B) to a symbol code: (+,+) gives 2'b00, (-,+) gives 2'b01, (-,-) gives 2'b11, and (+,-) gives 2'b10.
- R7: A branch value of exactly zero counts as positive in the decision.
- R8: `out_valid` rises on the edge after a symbol is produced. With `out_ready` high it stays up for one clock, unless another symbol is produced at that same edge. With `out_ready` low, `out_valid` and `out_sym` stay unchanged until the symbol is taken.
- R9: A synchronous reset clears the symbol counter, every filter delay line and `out_valid`. After reset, numbering restarts at j = 0 with empty filter history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample and references are valid |
| in_ready | output | 1 | Block can take a sample |
| in_sample | input | 8 | Signed received sample |
| in_ref_ahead | input | 8 | Signed reference at carrier +45 degrees |
| in_ref_behind | input | 8 | Signed reference at carrier -45 degrees |
| out_valid | output | 1 | Symbol available |
| out_ready | input | 1 | Consumer takes the symbol |
| out_sym | output | 2 | Gray-coded symbol |

## Verification
The bench runs -128 * -128 through the mixers. A product that wraps would flip the branch sign and give the wrong symbol. An all-zero stretch must settle to code 00; a design that treated zero as negative would report 11. The bench also runs a synthetic carrier at every symbol phase and stalls the output at random. A design that let samples in during a stall, or changed a held symbol, would fall out of step with the reference model's symbol sequence. A mid-run reset is followed by a fresh symbol count. Stale filter history or a stale counter would shift or corrupt the first decisions.

// File: rtl/qpsk_demod_pkg.sv
package qpsk_demod_pkg;

  typedef enum logic [1:0] {
    SYM_PP = 2'b00,
    SYM_NP = 2'b01,
    SYM_NN = 2'b11,
    SYM_PN = 2'b10
  } sym_code_e;

  function automatic sym_code_e sign_to_sym(input logic neg_a, input logic neg_b);
    case ({neg_a, neg_b})
      2'b00:   return SYM_PP;
      2'b10:   return SYM_NP;
      2'b11:   return SYM_NN;
      default: return SYM_PN;
    endcase
  endfunction

endpackage

// File: rtl/qpsk_mixer.sv
module qpsk_mixer #(
  parameter int IN_W = 8,
  localparam int PW = 2 * IN_W
) (
  input  logic signed [IN_W-1:0] sample,
  input  logic signed [IN_W-1:0] ref_val,
  output logic signed [PW-1:0]   prod
);

  assign prod = PW'(sample) * PW'(ref_val);

  always_comb begin
    if (sample != '0 && ref_val != '0)
      assert_prod_sign_R2: assert (prod[PW-1] == (sample[IN_W-1] ^ ref_val[IN_W-1]));
  end

endmodule

// File: rtl/qpsk_csd_fir.sv
module qpsk_csd_fir #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int NTAP  = 4,
  parameter int CW    = 8,
  parameter int SHIFT = 5,
  parameter logic [NTAP*CW-1:0] COEFS = 32'h030B0B03,
  localparam int ACC_W = IN_W + CW + $clog2(NTAP) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  x,
  output logic signed [OUT_W-1:0] y
);

  function automatic logic signed [ACC_W-1:0] csd_mul(
    input logic signed [IN_W-1:0] v, input int c);
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] ve;
    int r;
    int d;
    acc = '0;
    ve  = ACC_W'(v);
    r   = c;
    for (int i = 0; i <= CW; i++) begin
      if (r[0]) begin
        d = ((r & 3) == 1) ? 1 : -1;
        if (d > 0) acc = acc + (ve <<< i);
        else       acc = acc - (ve <<< i);
        r = r - d;
      end
      r = r >>> 1;
    end
    return acc;
  endfunction

  logic signed [IN_W-1:0]  tap  [NTAP];
  logic signed [ACC_W-1:0] term [NTAP];
  logic signed [ACC_W-1:0] acc_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAP; k++) tap[k] <= '0;
    end else if (en) begin
      tap[0] <= x;
      for (int k = 1; k < NTAP; k++) tap[k] <= tap[k-1];
    end
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    localparam logic signed [CW-1:0] CK = COEFS[k*CW +: CW];
    assign term[k] = csd_mul(tap[k], int'(CK));
    if (k > 0) begin : g_chk
      assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
        en |=> tap[k] == $past(tap[k-1]));
      assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(tap[k]));
    end
  end

  always_comb begin
    acc_sum = '0;
    for (int k = 0; k < NTAP; k++) acc_sum = acc_sum + term[k];
  end

  assign y = OUT_W'(acc_sum >>> SHIFT);

endmodule

// File: rtl/qpsk_sym_timer.sv
module qpsk_sym_timer #(
  parameter int SPS   = 4,
  parameter int PHASE = 2,
  localparam int CNT_W = (SPS > 1) ? $clog2(SPS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic strobe
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                            cnt <= '0;
    else if (en && cnt == CNT_W'(SPS-1)) cnt <= '0;
    else if (en)                        cnt <= cnt + 1'b1;
  end

  assign strobe = (cnt == CNT_W'(PHASE));

  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < SPS);
  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == CNT_W'(SPS-1)) |=> cnt == '0);
  assert_reset_R9: assert property (@(posedge clk)
    $past(rst) |-> cnt == '0);

endmodule

// File: rtl/qpsk_demod_top.sv
module qpsk_demod_top #(
  parameter int IN_W     = 8,
  parameter int FO_W     = 16,
  parameter int CW       = 8,
  parameter int LPF_N    = 5,
  parameter int LPF_SH   = 5,
  parameter logic [LPF_N*CW-1:0] LPF_C = 40'hFF060D06FF,
  parameter int MF_N     = 4,
  parameter int MF_SH    = 5,
  parameter logic [MF_N*CW-1:0] MF_C = 32'h030B0B03,
  parameter int SPS      = 4,
  parameter int PHASE    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_sample,
  input  logic [IN_W-1:0] in_ref_ahead,
  input  logic [IN_W-1:0] in_ref_behind,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [1:0]      out_sym
);
  import qpsk_demod_pkg::*;

  localparam int PW = 2 * IN_W;
  localparam int NBR = 2;

  logic en;
  logic strobe;
  logic signed [PW-1:0]   prod  [NBR];
  logic signed [FO_W-1:0] lpf_y [NBR];
  logic signed [FO_W-1:0] mf_y  [NBR];
  sym_code_e decision;

  assign in_ready = !(out_valid && !out_ready);
  assign en       = in_valid && in_ready;

  for (genvar b = 0; b < NBR; b++) begin : g_branch
    logic signed [IN_W-1:0] ref_sel;
    assign ref_sel = (b == 0) ? $signed(in_ref_ahead) : $signed(in_ref_behind);

    qpsk_mixer #(.IN_W(IN_W)) u_mix (
      .sample ($signed(in_sample)),
      .ref_val(ref_sel),
      .prod   (prod[b])
    );

    qpsk_csd_fir #(
      .IN_W(PW), .OUT_W(FO_W), .NTAP(LPF_N), .CW(CW),
      .SHIFT(LPF_SH), .COEFS(LPF_C)
    ) u_lpf (
      .clk(clk), .rst(rst), .en(en), .x(prod[b]), .y(lpf_y[b])
    );

    qpsk_csd_fir #(
      .IN_W(FO_W), .OUT_W(FO_W), .NTAP(MF_N), .CW(CW),
      .SHIFT(MF_SH), .COEFS(MF_C)
    ) u_mf (
      .clk(clk), .rst(rst), .en(en), .x(lpf_y[b]), .y(mf_y[b])
    );
  end

  qpsk_sym_timer #(.SPS(SPS), .PHASE(PHASE)) u_timer (
    .clk(clk), .rst(rst), .en(en), .strobe(strobe)
  );

  assign decision = sign_to_sym(mf_y[0][FO_W-1], mf_y[1][FO_W-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sym   <= 2'b00;
    end else if (en && strobe) begin
      out_valid <= 1'b1;
      out_sym   <= decision;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym)));
  assert_backpressure_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
  assert_new_sym_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(en && strobe));
  assert_reset_clear_R9: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

endmodule

// File: tb/qpsk_demod_top_test.sv
`timescale 1ns/1ps
module qpsk_demod_top_test;
  localparam int SPS = 4, PH = 2, MAXS = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [7:0] smp = '0, ra = '0, rb = '0;
  logic in_ready, out_valid;
  logic [1:0] out_sym;

  always #2 clk = ~clk;

  qpsk_demod_top uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(smp), .in_ref_ahead(ra), .in_ref_behind(rb),
    .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int lc [5] = '{-1, 6, 13, 6, -1};
  int hc [4] = '{3, 11, 11, 3};
  int pa [MAXS]; int pb [MAXS];
  int la [MAXS]; int lb [MAXS];
  int ma [MAXS]; int mb [MAXS];
  int nacc = 0;
  int expq [$];
  int last_code = -1;
  bit held_flag = 1'b0;
  int held_val = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sym_of(input int a, input int b);
    if (a >= 0 && b >= 0) return 0;
    if (a < 0 && b >= 0)  return 1;
    if (a < 0 && b < 0)   return 3;
    return 2;
  endfunction

  function automatic int s8(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  // R3 / R4 reference: direct convolutions with floor division by 32
  task automatic record_accept();
    int j, sa, sb;
    j = nacc;
    pa[j] = s8(smp) * s8(ra);
    pb[j] = s8(smp) * s8(rb);
    sa = 0; sb = 0;
    for (int k = 0; k < 5; k++)
      if (j - k >= 0) begin sa += lc[k] * pa[j-k]; sb += lc[k] * pb[j-k]; end
    la[j] = sa >>> 5; lb[j] = sb >>> 5;
    sa = 0; sb = 0;
    for (int k = 0; k < 4; k++)
      if (j - k >= 0) begin sa += hc[k] * la[j-k]; sb += hc[k] * lb[j-k]; end
    ma[j] = sa >>> 5; mb[j] = sb >>> 5;
    if (j % SPS == PH)
      expq.push_back(j >= 2 ? sym_of(ma[j-2], mb[j-2]) : 0);
    nacc++;
  endtask

  task automatic step(input bit iv, input int s, input int a, input int b,
                      input bit ordy, input string tag);
    int e;
    @(negedge clk);
    in_valid = iv; smp = s[7:0]; ra = a[7:0]; rb = b[7:0]; out_ready = ordy;
    #1;
    if (held_flag && out_valid) chk(int'(out_sym) == held_val, "R8 held", int'(out_sym), held_val);
    if (out_valid && !out_ready) begin
      chk(in_ready == 1'b0, "R1 backpressure", int'(in_ready), 0);
      held_flag = 1'b1; held_val = int'(out_sym);
    end else held_flag = 1'b0;
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(1'b0, "R8 extra symbol", int'(out_sym), -1);
      else begin
        e = expq.pop_front();
        chk(int'(out_sym) == e, tag, int'(out_sym), e);
      end
      last_code = int'(out_sym);
    end
    if (in_valid && in_ready) record_accept();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    nacc = 0; expq.delete(); held_flag = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
  endtask

  task automatic drain();
    repeat (3) step(1'b0, 0, 0, 0, 1'b1, "R8 drain");
  endtask

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  initial begin
    int sa_t [4] = '{100, -100, -100, 100};
    int sb_t [4] = '{100, 100, -100, -100};
    int code_t [4] = '{0, 1, 3, 2};
    real pi;
    int phase_code [4] = '{0, 2, 3, 1};
    int seed, dummy;
    pi = 3.14159265358979;
    seed = 20240611;
    dummy = int'($urandom(seed));

    do_reset();

    // R6: constant branch sign combinations
    for (int c = 0; c < 4; c++) begin
      for (int n = 0; n < 24; n++) step(1'b1, 100, sa_t[c], sb_t[c], 1'b1, "R6 sign combo");
      drain();
      chk(last_code == code_t[c], "R6 settled code", last_code, code_t[c]);
    end

    // R7: all-zero branches
    for (int n = 0; n < 24; n++) step(1'b1, 0, 50, -50, 1'b1, "R7 zero branch");
    drain();
    chk(last_code == 0, "R7 zero is positive", last_code, 0);

    // R2: extreme product without wrap
    for (int n = 0; n < 24; n++) step(1'b1, -128, -128, 127, 1'b1, "R2 extreme product");
    drain();
    chk(last_code == 2, "R2 full width product", last_code, 2);

    // R9: mid-run reset, stall pending symbol first
    for (int n = 0; n < 6; n++) step(1'b1, -90, 80, 80, 1'b0, "R9 before reset");
    do_reset();
    for (int n = 0; n < 12; n++) step(1'b1, 70, -60, 90, 1'b1, "R9 after reset");
    drain();

    // R6 / R5: synthetic carrier at fs/4, four symbol phases
    for (int q = 0; q < 4; q++) begin
      for (int n = 0; n < 32; n++) begin
        real th;
        th = pi / 2.0 * n;
        step(1'b1, rnd(100.0 * $cos(th + q * pi / 2.0)),
             rnd(90.0 * $cos(th + pi / 4.0)), rnd(90.0 * $cos(th - pi / 4.0)),
             1'b1, "R5 carrier phase");
      end
      drain();
      chk(last_code == phase_code[q], "R6 carrier phase symbol", last_code, phase_code[q]);
    end

    // R1 / R8 / R5: random stimulus with random back-pressure
    for (int n = 0; n < 1500; n++) begin
      step(($urandom % 4) != 0, int'($urandom % 256) - 128, int'($urandom % 256) - 128,
           int'($urandom % 256) - 128, ($urandom % 10) < 7, "R5 random");
      if (nacc >= MAXS - 8) do_reset();
    end
    drain();
    chk(expq.size() == 0, "R8 all symbols delivered", expq.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule